// File: doc/BRIEF.md
# Per-Pin Selectable Input Debounce Filter

This block cleans up a bank of slow, noisy input pins. Three shared period registers each hold a debounce time counted in clock cycles. Each pin picks one of them, or none, through a two-bit timer index. The two bits of that index live in two separate bitmap registers. One bitmap holds the upper bit of every pin's index and the other holds the lower bit, each at the pin's own bit position.

A pin whose index is zero is not filtered: its output follows the raw input in the same cycle. A pin with a non-zero index keeps its filtered level until the raw input has stayed at a different level for the selected number of cycles. Software works out the period as the wanted time multiplied by the clock rate, rounded up, and decides which pins share which timer. The block only applies that choice.

Top module: `dbnc_sel_filter`

## Requirements
- R1: After reset all three periods and both select bitmaps are zero, so every pin runs in bypass and `filt_o` equals `raw_i`.
- R2: A pin whose timer index is 0 drives `filt_o` from `raw_i` combinationally, so a change appears in the same cycle.
- R3: A write with `cfg_addr` 4 loads the upper index bit of every pin from `cfg_wdata`, one bit per pin at the pin's own position. `cfg_addr` 5 loads the lower index bit in the same way. Addresses 1, 2 and 3 load the period of timers 1, 2 and 3.
- R4: With a non-zero index and period P ≥ 1, `filt_o` takes a new raw level at the P-th rising edge at which the raw input differs from the filtered level, counting every edge of an unbroken run.
- R5: A raw pulse that lasts fewer than P edges never reaches `filt_o`. Returning to the filtered level clears the count, so a later change must again last a full P edges.
- R6: A period of 0 behaves like a period of 1: the output follows one edge after the raw change.
- R7: A write to the period register of a pin's selected timer, or a write that changes the pin's index, restarts that pin's count. A full P edges are then needed after the write edge.
- R8: Pins that select different timers are filtered by their own periods independently, in the same cycles.
- R9: Writes with `cfg_addr` 0, 6 or 7 change no period and no select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; periods count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 1–3 periods, 4 upper index bits, 5 lower index bits |
| cfg_wdata | input | 32 | Write data |
| raw_i | input | NPINS | Unfiltered pin levels |
| filt_o | output | NPINS | Debounced pin levels |

## Verification
A configuration write that restarts a count can fall on the same edge at which a pin's raw input is still counting toward its period. The bench provokes this by dropping one pin's input, letting three of its five edges pass, and then rewriting that pin's period. The output must still hold after four further edges and must change at the fifth. In the same run a pin on a zero-length period and a bypassed pin react within one edge while other pins are still counting, which shows that several pins update in the same cycle without affecting one another.

// File: rtl/dbnc_sel_filter.sv
module dbnc_sel_filter #(
  parameter int NPINS = 32,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [NPINS-1:0] raw_i,
  output logic [NPINS-1:0] filt_o
);
  localparam logic [2:0] A_SEL_HI = 3'd4;
  localparam logic [2:0] A_SEL_LO = 3'd5;

  logic [CW-1:0]    per1_q, per2_q, per3_q;
  logic [NPINS-1:0] sel_hi_q, sel_lo_q, sel_hi_nx, sel_lo_nx;
  logic             wr_per;

  assign wr_per    = cfg_we && (cfg_addr >= 3'd1) && (cfg_addr <= 3'd3);
  assign sel_hi_nx = (cfg_we && cfg_addr == A_SEL_HI) ? cfg_wdata[NPINS-1:0] : sel_hi_q;
  assign sel_lo_nx = (cfg_we && cfg_addr == A_SEL_LO) ? cfg_wdata[NPINS-1:0] : sel_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per1_q   <= '0;
      per2_q   <= '0;
      per3_q   <= '0;
      sel_hi_q <= '0;
      sel_lo_q <= '0;
    end else begin
      sel_hi_q <= sel_hi_nx;
      sel_lo_q <= sel_lo_nx;
      if (cfg_we && cfg_addr == 3'd1) per1_q <= cfg_wdata[CW-1:0];
      if (cfg_we && cfg_addr == 3'd2) per2_q <= cfg_wdata[CW-1:0];
      if (cfg_we && cfg_addr == 3'd3) per3_q <= cfg_wdata[CW-1:0];
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0]    idx, idx_nx;
    logic [CW-1:0] per, lim, cnt;
    logic          filt_q, bypass, restart;

    assign idx     = {sel_hi_q[i], sel_lo_q[i]};
    assign idx_nx  = {sel_hi_nx[i], sel_lo_nx[i]};
    assign bypass  = (idx == 2'd0);
    assign restart = (idx_nx != idx) || (wr_per && cfg_addr[1:0] == idx && !bypass);

    always_comb begin
      case (idx)
        2'd1:    per = per1_q;
        2'd2:    per = per2_q;
        2'd3:    per = per3_q;
        default: per = '0;
      endcase
    end
    assign lim = (per == '0) ? '0 : per - 1'b1;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filt_q <= 1'b0;
        cnt    <= '0;
      end else if (bypass) begin
        filt_q <= raw_i[i];
        cnt    <= '0;
      end else if (restart || raw_i[i] == filt_q) begin
        cnt    <= '0;
      end else if (cnt >= lim) begin
        filt_q <= raw_i[i];
        cnt    <= '0;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end

    assign filt_o[i] = bypass ? raw_i[i] : filt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);  // R4
    AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && cnt < lim) |=> $stable(filt_q));  // R5
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_i[i] == filt_q) |=> (cnt == '0));  // R5
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0) && $stable(filt_q));  // R7
  end

  AST_RESET_BYPASS: assert property (@(posedge clk)
    !rst_n |=> (sel_hi_q == '0) && (sel_lo_q == '0));  // R1
  AST_IGNORED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == 3'd0 || cfg_addr > A_SEL_LO))
      |=> $stable(sel_hi_q) && $stable(sel_lo_q) && $stable(per1_q)
          && $stable(per2_q) && $stable(per3_q));  // R9
endmodule

// File: tb/dbnc_sel_filter_tb_top.sv
module dbnc_sel_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] raw_i = '0;
  logic [31:0] filt_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dbnc_sel_filter #(.NPINS(32), .CW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .raw_i(raw_i), .filt_o(filt_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    raw_i = 32'hA5A5_0F0F; #1;
    chk("R1 reset bypass", filt_o, 32'hA5A5_0F0F);
    raw_i = 32'h0000_0000; #1;
    chk("R2 same-cycle pass", filt_o, 32'h0);
    step(1);
  endtask

  // pin0 idx0, pin1 timer1 (P=3), pin2 timer2 (P=5), pin3 timer3 (P=0)
  task automatic t_timers;
    wr(3'd1, 32'd3); wr(3'd2, 32'd5); wr(3'd3, 32'd0);
    wr(3'd4, 32'h0000_000C); wr(3'd5, 32'h0000_000A);
    step(1);
    raw_i[3:0] = 4'hF; #1;
    chk("R2 bypass pin follows at once", filt_o[3:0], 4'h1);
    step(1);
    chk("R6 zero period one edge", filt_o[3:0], 4'h9);
    step(1);
    chk("R4 timer1 not yet at edge 2", filt_o[3:0], 4'h9);
    step(1);
    chk("R4 R3 timer1 at edge 3", filt_o[3:0], 4'hB);
    step(1);
    chk("R8 timer2 not yet at edge 4", filt_o[3:0], 4'hB);
    step(1);
    chk("R8 R3 timer2 at edge 5", filt_o[3:0], 4'hF);
  endtask

  task automatic t_glitch;
    raw_i[1] = 1'b0;
    step(2);
    raw_i[1] = 1'b1;
    step(1);
    raw_i[1] = 1'b0;
    step(2);
    chk("R5 short pulses blocked", {31'b0, filt_o[1]}, 32'd1);
    step(1);
    chk("R5 full run passes", {31'b0, filt_o[1]}, 32'd0);
  endtask

  task automatic t_restart;
    raw_i[2] = 1'b0;
    step(3);
    wr(3'd2, 32'd5);
    step(4);
    chk("R7 restart holds output", {31'b0, filt_o[2]}, 32'd1);
    step(1);
    chk("R7 full period after write", {31'b0, filt_o[2]}, 32'd0);
  endtask

  task automatic t_ignored;
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    raw_i[0] = 1'b0; #1;
    chk("R9 pin0 still bypass", {31'b0, filt_o[0]}, 32'd0);
    raw_i[1] = 1'b1;
    step(2);
    chk("R9 timer1 period unchanged early", {31'b0, filt_o[1]}, 32'd0);
    step(1);
    chk("R9 timer1 period unchanged", {31'b0, filt_o[1]}, 32'd1);
    chk("R9 other pins idle", filt_o[31:4], 28'h0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timers();
    t_glitch();
    t_restart();
    t_ignored();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule